// File: doc/BRIEF.md
# Memory Access Permission Checker

This block decides, for a single memory access, what rights the access holds and whether it may proceed. It belongs in a page-table walker that uses domains. The walker fetches a descriptor and extracts two things: the two-bit access value of the domain the descriptor names, and the two-bit permission field that applies to the addressed region. It then presents both, together with the two protection control bits, the processor mode, a forced-user flag and the direction of the access. The block returns a three-level rights code, a grant bit and a flag for encodings that are reserved or unpredictable.

The domain value is applied first. A no-access domain refuses the access. A manager domain allows full access. A client domain passes the decision to the permission field, which is read differently for privileged and user accesses. The grant comes from comparing the rights code with the write flag. When `REG_OUT` is set, all three outputs are registered.

Top module: `mmu_perm_check`

## Requirements
- R1: The rights code uses 0 for no access, 1 for read-only and 2 for read/write, and it never takes the value 3. A domain value of 0 yields rights 0 with the reserved flag low.
- R2: A domain value of 3 yields rights 2 with the reserved flag low, whatever the permission field, control bits or mode.
- R3: A domain value of 2 is reserved. It yields rights 0 and raises the reserved flag.
- R4: With domain value 1 and permission field 0, the result depends on ctl_sys and ctl_rom. Both low gives rights 0. ctl_sys alone gives rights 1 for a privileged access and 0 for a user access. ctl_rom alone gives rights 1 in every mode. Both high gives rights 0 and raises the reserved flag.
- R5: With domain value 1 and permission field 1, a privileged access gets rights 2 and a user access gets rights 0.
- R6: With domain value 1 and permission field 2, a privileged access gets rights 2 and a user access gets rights 1.
- R7: With domain value 1 and permission field 3, every access gets rights 2.
- R8: An access counts as a user access when cpu_mode equals USER_MODE (default 5'h10), or when force_user is high. Any other mode value counts as privileged.
- R9: grant is high exactly when the rights code is strictly greater than is_write, where is_write is 0 for a read and 1 for a write.
- R10: With REG_OUT=1, the outputs show the result for the inputs sampled at the previous rising clock edge. While rst is high at an edge, the outputs are cleared to rights 0, grant 0 and reserved 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| dom_acc | input | 2 | Access value of the selected domain |
| ap_fld | input | 2 | Permission field for the addressed region |
| ctl_sys | input | 1 | System protection control bit |
| ctl_rom | input | 1 | ROM protection control bit |
| cpu_mode | input | MODE_W | Current processor mode field |
| force_user | input | 1 | Check the access with user rights whatever the mode |
| is_write | input | 1 | 1 for a write access, 0 for a read |
| rights | output | 2 | Rights code: 0 none, 1 read-only, 2 read/write |
| grant | output | 1 | Access allowed |
| reserved_enc | output | 1 | Reserved domain value or unpredictable control combination |

## Verification
Two cases are hard to reach. One is a forced-user access from a privileged mode. The other is permission field 0 with both control bits set inside a client domain. Each depends on several independent inputs lining up at once. The stimulus therefore sweeps every combination of domain value, permission field, control bits, forced-user flag and direction, using one user and one privileged mode. A seeded random phase follows that also draws arbitrary mode values, so modes close to the user encoding are tried as privileged.

// File: rtl/mmu_perm_pkg.sv
package mmu_perm_pkg;
  localparam int RGT_W = 2;

  typedef enum logic [RGT_W-1:0] {
    RGT_NONE = 2'd0,
    RGT_RO   = 2'd1,
    RGT_RW   = 2'd2
  } rights_e;

  typedef enum logic [1:0] {
    DOM_NOACC   = 2'd0,
    DOM_CLIENT  = 2'd1,
    DOM_RSVD    = 2'd2,
    DOM_MANAGER = 2'd3
  } dom_e;
endpackage

// File: rtl/mmu_mode_classify.sv
module mmu_mode_classify #(
  parameter int MODE_W = 5,
  parameter logic [MODE_W-1:0] USER_MODE = 5'h10
) (
  input  logic [MODE_W-1:0] cpu_mode,
  input  logic              force_user,
  output logic              is_user
);
  always_comb begin
    is_user = force_user || (cpu_mode == USER_MODE);
  end
endmodule

// File: rtl/mmu_ap_decode.sv
module mmu_ap_decode
  import mmu_perm_pkg::*;
(
  input  logic [1:0] ap_fld,
  input  logic       ctl_sys,
  input  logic       ctl_rom,
  input  logic       is_user,
  output rights_e    ap_rights,
  output logic       ap_unpred
);
  always_comb begin
    ap_rights = RGT_NONE;
    ap_unpred = 1'b0;
    unique case (ap_fld)
      2'd0: begin
        unique case ({ctl_rom, ctl_sys})
          2'b00: ap_rights = RGT_NONE;
          2'b01: ap_rights = is_user ? RGT_NONE : RGT_RO;
          2'b10: ap_rights = RGT_RO;
          default: begin
            ap_rights = RGT_NONE;
            ap_unpred = 1'b1;
          end
        endcase
      end
      2'd1:    ap_rights = is_user ? RGT_NONE : RGT_RW;
      2'd2:    ap_rights = is_user ? RGT_RO : RGT_RW;
      default: ap_rights = RGT_RW;
    endcase
  end
endmodule

// File: rtl/mmu_domain_gate.sv
module mmu_domain_gate
  import mmu_perm_pkg::*;
(
  input  logic [1:0] dom_acc,
  input  rights_e    ap_rights,
  input  logic       ap_unpred,
  output rights_e    dom_rights,
  output logic       dom_rsvd
);
  dom_e dom;

  always_comb begin
    dom        = dom_e'(dom_acc);
    dom_rights = RGT_NONE;
    dom_rsvd   = 1'b0;
    unique case (dom)
      DOM_NOACC:   dom_rights = RGT_NONE;
      DOM_CLIENT: begin
        dom_rights = ap_rights;
        dom_rsvd   = ap_unpred;
      end
      DOM_RSVD: begin
        dom_rights = RGT_NONE;
        dom_rsvd   = 1'b1;
      end
      default:     dom_rights = RGT_RW;
    endcase
  end
endmodule

// File: rtl/mmu_grant_cmp.sv
module mmu_grant_cmp
  import mmu_perm_pkg::*;
(
  input  rights_e rights_in,
  input  logic    is_write,
  output logic    grant
);
  always_comb begin
    grant = rights_in > {1'b0, is_write};
  end
endmodule

// File: rtl/mmu_perm_check.sv
module mmu_perm_check
  import mmu_perm_pkg::*;
#(
  parameter int MODE_W = 5,
  parameter logic [MODE_W-1:0] USER_MODE = 5'h10,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        dom_acc,
  input  logic [1:0]        ap_fld,
  input  logic              ctl_sys,
  input  logic              ctl_rom,
  input  logic [MODE_W-1:0] cpu_mode,
  input  logic              force_user,
  input  logic              is_write,
  output logic [RGT_W-1:0]  rights,
  output logic              grant,
  output logic              reserved_enc
);
  logic    usr;
  rights_e ap_r;
  logic    ap_u;
  rights_e dom_r;
  logic    dom_x;
  logic    grant_c;

  mmu_mode_classify #(.MODE_W(MODE_W), .USER_MODE(USER_MODE)) u_mode (
    .cpu_mode  (cpu_mode),
    .force_user(force_user),
    .is_user   (usr)
  );

  mmu_ap_decode u_ap (
    .ap_fld   (ap_fld),
    .ctl_sys  (ctl_sys),
    .ctl_rom  (ctl_rom),
    .is_user  (usr),
    .ap_rights(ap_r),
    .ap_unpred(ap_u)
  );

  mmu_domain_gate u_dom (
    .dom_acc   (dom_acc),
    .ap_rights (ap_r),
    .ap_unpred (ap_u),
    .dom_rights(dom_r),
    .dom_rsvd  (dom_x)
  );

  mmu_grant_cmp u_cmp (
    .rights_in(dom_r),
    .is_write (is_write),
    .grant    (grant_c)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          rights       <= RGT_NONE;
          grant        <= 1'b0;
          reserved_enc <= 1'b0;
        end else begin
          rights       <= dom_r;
          grant        <= grant_c;
          reserved_enc <= dom_x;
        end
      end
    end else begin : g_comb
      assign rights       = dom_r;
      assign grant        = grant_c;
      assign reserved_enc = dom_x;
    end
  endgenerate
endmodule

// File: rtl/mmu_perm_check_sva.sv
module mmu_perm_check_sva #(
  parameter int MODE_W = 5,
  parameter logic [MODE_W-1:0] USER_MODE = 5'h10,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        dom_acc,
  input logic [1:0]        ap_fld,
  input logic              ctl_sys,
  input logic              ctl_rom,
  input logic [MODE_W-1:0] cpu_mode,
  input logic              force_user,
  input logic              is_write,
  input logic [1:0]        rights,
  input logic              grant,
  input logic              reserved_enc
);
  logic [1:0]        c_dom;
  logic [1:0]        c_ap;
  logic [MODE_W-1:0] c_mode;
  logic              c_force;
  logic              c_wr;
  logic              c_ok;
  logic              c_usr;

  generate
    if (REG_OUT) begin : g_lat
      always_ff @(posedge clk) begin
        if (rst) begin
          c_ok <= 1'b0;
        end else begin
          c_ok <= 1'b1;
        end
        c_dom   <= dom_acc;
        c_ap    <= ap_fld;
        c_mode  <= cpu_mode;
        c_force <= force_user;
        c_wr    <= is_write;
      end

      // R10: first sample after reset shows the cleared state
      p_reset_clear_r10: assert property (@(posedge clk) disable iff (rst)
        !c_ok |-> (rights == 2'd0 && !grant && !reserved_enc));
    end else begin : g_now
      assign c_ok    = 1'b1;
      assign c_dom   = dom_acc;
      assign c_ap    = ap_fld;
      assign c_mode  = cpu_mode;
      assign c_force = force_user;
      assign c_wr    = is_write;
    end
  endgenerate

  assign c_usr = c_force || (c_mode == USER_MODE);

  p_rights_legal_r1: assert property (@(posedge clk) disable iff (rst)
    c_ok |-> rights != 2'd3);

  p_dom_none_r1: assert property (@(posedge clk) disable iff (rst)
    (c_ok && c_dom == 2'd0) |-> (rights == 2'd0 && !reserved_enc));

  p_dom_manager_r2: assert property (@(posedge clk) disable iff (rst)
    (c_ok && c_dom == 2'd3) |-> (rights == 2'd2 && !reserved_enc));

  p_dom_reserved_r3: assert property (@(posedge clk) disable iff (rst)
    (c_ok && c_dom == 2'd2) |-> (rights == 2'd0 && reserved_enc));

  p_ap_priv_only_r5: assert property (@(posedge clk) disable iff (rst)
    (c_ok && c_dom == 2'd1 && c_ap == 2'd1) |->
      (rights == (c_usr ? 2'd0 : 2'd2)));

  p_ap_user_ro_r6: assert property (@(posedge clk) disable iff (rst)
    (c_ok && c_dom == 2'd1 && c_ap == 2'd2) |->
      (rights == (c_usr ? 2'd1 : 2'd2)));

  p_ap_full_r7: assert property (@(posedge clk) disable iff (rst)
    (c_ok && c_dom == 2'd1 && c_ap == 2'd3) |-> rights == 2'd2);

  p_grant_cmp_r9: assert property (@(posedge clk) disable iff (rst)
    c_ok |-> (grant == (rights > {1'b0, c_wr})));

  logic unused_ctl;
  assign unused_ctl = ctl_sys ^ ctl_rom;
endmodule

bind mmu_perm_check mmu_perm_check_sva #(
  .MODE_W(MODE_W), .USER_MODE(USER_MODE), .REG_OUT(REG_OUT)
) u_sva (
  .clk(clk), .rst(rst), .dom_acc(dom_acc), .ap_fld(ap_fld),
  .ctl_sys(ctl_sys), .ctl_rom(ctl_rom), .cpu_mode(cpu_mode),
  .force_user(force_user), .is_write(is_write), .rights(rights),
  .grant(grant), .reserved_enc(reserved_enc)
);

// File: tb/mmu_perm_check_tb.sv
`timescale 1ns/1ps
module mmu_perm_check_tb;
  localparam int MODE_W = 5;
  localparam logic [MODE_W-1:0] USER_MODE = 5'h10;
  localparam logic [MODE_W-1:0] PRIV_MODE = 5'h13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] dom_acc = '0;
  logic [1:0] ap_fld = '0;
  logic ctl_sys = 1'b0;
  logic ctl_rom = 1'b0;
  logic [MODE_W-1:0] cpu_mode = PRIV_MODE;
  logic force_user = 1'b0;
  logic is_write = 1'b0;
  logic [1:0] rights;
  logic grant;
  logic reserved_enc;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mmu_perm_check #(.MODE_W(MODE_W), .USER_MODE(USER_MODE), .REG_OUT(1'b1)) u_dut (
    .clk(clk), .rst(rst), .dom_acc(dom_acc), .ap_fld(ap_fld),
    .ctl_sys(ctl_sys), .ctl_rom(ctl_rom), .cpu_mode(cpu_mode),
    .force_user(force_user), .is_write(is_write), .rights(rights),
    .grant(grant), .reserved_enc(reserved_enc)
  );

  function automatic logic [1:0] exp_rights(logic [1:0] d, logic [1:0] a,
                                            logic s, logic r, logic u);
    if (d == 2'd0 || d == 2'd2) return 2'd0;
    if (d == 2'd3) return 2'd2;
    case (a)
      2'd0: begin
        if (s && r) return 2'd0;
        if (r) return 2'd1;
        if (s) return u ? 2'd0 : 2'd1;
        return 2'd0;
      end
      2'd1: return u ? 2'd0 : 2'd2;
      2'd2: return u ? 2'd1 : 2'd2;
      default: return 2'd2;
    endcase
  endfunction

  function automatic logic exp_rsvd(logic [1:0] d, logic [1:0] a, logic s, logic r);
    return (d == 2'd2) || (d == 2'd1 && a == 2'd0 && s && r);
  endfunction

  function automatic string req_tag(logic [1:0] d, logic [1:0] a);
    if (d == 2'd0) return "R1";
    if (d == 2'd2) return "R3";
    if (d == 2'd3) return "R2";
    case (a)
      2'd0: return "R4";
      2'd1: return "R5";
      2'd2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check3(string tag, logic [1:0] er, logic eg, logic ex);
    n_cmp++;
    if (rights !== er || grant !== eg || reserved_enc !== ex) begin
      n_bad++;
      $display("FAIL %s: rights/grant/rsvd actual %0d/%0d/%0d expected %0d/%0d/%0d",
               tag, rights, grant, reserved_enc, er, eg, ex);
    end
  endtask

  task automatic drive(logic [1:0] d, logic [1:0] a, logic s, logic r,
                       logic [MODE_W-1:0] m, logic f, logic w);
    dom_acc = d; ap_fld = a; ctl_sys = s; ctl_rom = r;
    cpu_mode = m; force_user = f; is_write = w;
  endtask

  // Drive at a falling edge, check at the next falling edge (one register).
  task automatic run_one(logic [1:0] d, logic [1:0] a, logic s, logic r,
                         logic [MODE_W-1:0] m, logic f, logic w);
    logic u;
    logic [1:0] er;
    string tag;
    drive(d, a, s, r, m, f, w);
    @(negedge clk);
    u   = f || (m == USER_MODE);
    er  = exp_rights(d, a, s, r, u);
    tag = req_tag(d, a);
    if (f && m != USER_MODE) tag = {tag, "/R8"};
    check3(tag, er, er > {1'b0, w}, exp_rsvd(d, a, s, r));
    // R9: grant compared with the rights code on the ports
    n_cmp++;
    if (grant !== (er > {1'b0, w})) begin
      n_bad++;
      $display("FAIL R9: grant actual %0d expected %0d", grant, er > {1'b0, w});
    end
  endtask

  initial begin
    #(20.0 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // R10: reset state, with inputs that would otherwise give full access
    drive(2'd3, 2'd3, 1'b0, 1'b0, PRIV_MODE, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check3("R10 reset", 2'd0, 1'b0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check3("R10 after reset", 2'd2, 1'b1, 1'b0);

    // R10: latency, output holds until the next rising edge
    drive(2'd0, 2'd3, 1'b0, 1'b0, PRIV_MODE, 1'b0, 1'b0);
    #5;
    check3("R10 hold", 2'd2, 1'b1, 1'b0);
    @(negedge clk);
    check3("R10 update", 2'd0, 1'b0, 1'b0);

    // Directed corners
    run_one(2'd1, 2'd0, 1'b1, 1'b1, PRIV_MODE, 1'b0, 1'b0); // R4 unpredictable
    run_one(2'd2, 2'd3, 1'b0, 1'b0, PRIV_MODE, 1'b0, 1'b0); // R3
    run_one(2'd1, 2'd1, 1'b0, 1'b0, PRIV_MODE, 1'b1, 1'b1); // R8 forced user
    run_one(2'd1, 2'd2, 1'b0, 1'b0, USER_MODE, 1'b0, 1'b1); // R6 user write
    run_one(2'd1, 2'd2, 1'b0, 1'b0, USER_MODE, 1'b0, 1'b0); // R6 user read

    // Exhaustive sweep over encodings, two modes, forced flag and direction
    for (int i = 0; i < 512; i++) begin
      run_one(i[1:0], i[3:2], i[4], i[5], i[6] ? USER_MODE : PRIV_MODE, i[7], i[8]);
    end

    // Seeded random phase with arbitrary mode values
    for (int k = 0; k < 2000; k++) begin
      logic [31:0] rv;
      rv = $urandom;
      run_one(rv[1:0], rv[3:2], rv[4], rv[5], rv[12:8], rv[6] & rv[7], rv[13]);
    end

    // R10: reset in the middle of operation clears the outputs
    drive(2'd3, 2'd0, 1'b0, 1'b0, PRIV_MODE, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check3("R10 mid reset", 2'd0, 1'b0, 1'b0);
    rst = 1'b0;
    @(negedge clk);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule